// File: doc/BRIEF.md
# Indirect Extended Register Bridge

This block belongs to the management register file on the PHY side of an Ethernet link. Two register numbers in the 32-entry management space reach a much larger extended register space. The first is the control register, number 13. It holds a 5-bit device selector and a 2-bit function code. The second is the window register, number 14. Its meaning follows the function code. In address mode, a write to the window loads a 16-bit extended address. In one of the three data modes, an access to the window becomes a single read or write on the extended register port. That access uses the latched device and address.

The data modes differ only in what happens to the latched address after each access. One mode never moves it. One adds one after reads and after writes. One adds one after writes only. This lets software stream through consecutive extended registers without reloading the address.

To read, software writes the control register with the device and function 00. It then writes the register address into the window, writes the control register again with a data function, and reads the window. A write uses the same three set-up steps and ends with a write of the data into the window. The serial management framing and the extended registers themselves lie outside this block.

Top module: `xreg_window_bridge`

## Requirements
- R1: After reset the stored device selector, function code and latched address are all zero. A read of register 13 and a read of register 14 (in address mode) both return 0x0000.
- R2: A write to register 13 stores bits 4:0 as the device selector and bits 15:14 as the function code. Function codes are 00 address, 01 data without increment, 10 data with increment on reads and writes, and 11 data with increment on writes only. A read of register 13 returns those fields in the same positions, with bits 13:5 read as zero.
- R3: With function 00, a write to register 14 loads the 16-bit latched address and raises neither extended strobe.
- R4: With a data function, a read of register 14 raises `ext_rd` for exactly that cycle, with `ext_dev` and `ext_addr` equal to the stored selector and latched address. `mgmt_rdata` shows `ext_rdata` in the same cycle.
- R5: With a data function, a write to register 14 raises `ext_wr` for exactly that cycle, with the stored selector, the latched address, and `ext_wdata` equal to the written value.
- R6: With function 01, the latched address is unchanged after data reads and writes.
- R7: With function 10, the latched address increases by one after every data read and every data write.
- R8: With function 11, the latched address increases by one after every data write and is unchanged after data reads.
- R9: Incrementing the latched address from 0xFFFF gives 0x0000.
- R10: An access to any register number other than 13 or 14 raises no strobe and changes no state. Such a read returns 0x0000.
- R11: With function 00, a read of register 14 returns the latched address and raises no strobe.
- R12: When `mgmt_wr` and `mgmt_rd` are high in the same cycle, only the write takes effect. `mgmt_rdata` is 0x0000 whenever no read is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_wr | input | 1 | Management write, one cycle per access |
| mgmt_rd | input | 1 | Management read, one cycle per access |
| mgmt_reg | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data, valid in the read cycle |
| ext_dev | output | 5 | Extended device selector |
| ext_addr | output | 16 | Extended register address |
| ext_wdata | output | 16 | Extended write data |
| ext_wr | output | 1 | Extended write strobe |
| ext_rd | output | 1 | Extended read strobe |
| ext_rdata | input | 16 | Extended read data, returned in the strobe cycle |

## Verification
The hardest case to reach is the address wrapping from 0xFFFF to 0x0000 in the middle of a run of incrementing accesses. It only appears when a set-up sequence has placed the latched address at the top of the space before the data mode starts. A directed sequence loads 0xFFFE, then makes write-increment and read-increment accesses across the boundary. The random phase then mixes mode changes, window accesses and foreign register numbers. This shows that the increment policy follows the function code in force at the time of each access.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
   typedef enum logic [1:0] {
      FN_ADDR    = 2'b00,
      FN_DATA    = 2'b01,
      FN_INC_RW  = 2'b10,
      FN_INC_W   = 2'b11
   } xrb_fn_e;
endpackage

// File: rtl/xrb_ctrl_reg.sv
module xrb_ctrl_reg #(
   parameter int DATA_W = 16,
   parameter int DEV_W  = 5,
   parameter int FN_LSB = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DEV_W-1:0]    dev,
   output xrb_pkg::xrb_fn_e    fn,
   output logic [DATA_W-1:0]   rdback
);
   initial begin
      if (FN_LSB + 2 > DATA_W) $error("function field does not fit the data width");
      if (DEV_W > FN_LSB)      $error("device field overlaps the function field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev <= '0;
         fn  <= xrb_pkg::FN_ADDR;
      end else if (we) begin
         dev <= wdata[DEV_W-1:0];
         fn  <= xrb_pkg::xrb_fn_e'(wdata[FN_LSB +: 2]);
      end
   end

   always_comb begin
      rdback = '0;
      rdback[DEV_W-1:0]   = dev;
      rdback[FN_LSB +: 2] = fn;
   end

   a_r2_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(dev) && $stable(fn)));
endmodule

// File: rtl/xrb_addr_ptr.sv
module xrb_addr_ptr #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DATA_W-1:0]  load_val,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

   initial begin
      if (ADDR_W > DATA_W) $error("extended address wider than the window register");
      if (ADDR_W < 1)      $error("extended address width must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     addr <= '0;
      else if (load)  addr <= load_val[ADDR_W-1:0];
      else if (step)  addr <= addr + 1'b1;
   end

   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && addr == TOP) |=> addr == '0);
   a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/xrb_access_dec.sv
module xrb_access_dec #(
   parameter int REG_W    = 5,
   parameter int CTRL_IDX = 13,
   parameter int WIN_IDX  = 14
) (
   input  logic              mgmt_wr,
   input  logic              mgmt_rd,
   input  logic [REG_W-1:0]  mgmt_reg,
   input  xrb_pkg::xrb_fn_e  fn,
   output logic              ctrl_we,
   output logic              addr_load,
   output logic              x_wr,
   output logic              x_rd,
   output logic              step,
   output logic              rd_ctrl,
   output logic              rd_addr,
   output logic              rd_ext
);
   localparam logic [REG_W-1:0] CTRL_NUM = REG_W'(CTRL_IDX);
   localparam logic [REG_W-1:0] WIN_NUM  = REG_W'(WIN_IDX);

   initial begin
      if (CTRL_IDX == WIN_IDX) $error("control and window must be distinct");
      if (CTRL_IDX >= (1 << REG_W) || WIN_IDX >= (1 << REG_W)) $error("register index out of range");
   end

   logic hit_ctrl, hit_win, rd_only, data_fn;

   always_comb begin
      hit_ctrl  = (mgmt_reg == CTRL_NUM);
      hit_win   = (mgmt_reg == WIN_NUM);
      rd_only   = mgmt_rd && !mgmt_wr;
      data_fn   = (fn != xrb_pkg::FN_ADDR);
      ctrl_we   = mgmt_wr && hit_ctrl;
      addr_load = mgmt_wr && hit_win && !data_fn;
      x_wr      = mgmt_wr && hit_win && data_fn;
      x_rd      = rd_only && hit_win && data_fn;
      rd_ctrl   = rd_only && hit_ctrl;
      rd_addr   = rd_only && hit_win && !data_fn;
      rd_ext    = x_rd;
      unique case (fn)
         xrb_pkg::FN_INC_RW: step = x_wr || x_rd;
         xrb_pkg::FN_INC_W:  step = x_wr;
         default:            step = 1'b0;
      endcase
   end
endmodule

// File: rtl/xreg_window_bridge.sv
module xreg_window_bridge #(
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16,
   parameter int DEV_W    = 5,
   parameter int ADDR_W   = 16,
   parameter int CTRL_IDX = 13,
   parameter int WIN_IDX  = 14,
   parameter int FN_LSB   = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mgmt_wr,
   input  logic               mgmt_rd,
   input  logic [REG_W-1:0]   mgmt_reg,
   input  logic [DATA_W-1:0]  mgmt_wdata,
   output logic [DATA_W-1:0]  mgmt_rdata,
   output logic [DEV_W-1:0]   ext_dev,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [DATA_W-1:0]  ext_wdata,
   output logic               ext_wr,
   output logic               ext_rd,
   input  logic [DATA_W-1:0]  ext_rdata
);
   xrb_pkg::xrb_fn_e  fn;
   logic [DATA_W-1:0] ctrl_rb, addr_rb;
   logic ctrl_we, addr_load, step, rd_ctrl, rd_addr, rd_ext;

   xrb_ctrl_reg #(.DATA_W(DATA_W), .DEV_W(DEV_W), .FN_LSB(FN_LSB)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(mgmt_wdata),
      .dev(ext_dev), .fn(fn), .rdback(ctrl_rb));

   xrb_access_dec #(.REG_W(REG_W), .CTRL_IDX(CTRL_IDX), .WIN_IDX(WIN_IDX)) u_dec (
      .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_reg(mgmt_reg), .fn(fn),
      .ctrl_we(ctrl_we), .addr_load(addr_load), .x_wr(ext_wr), .x_rd(ext_rd),
      .step(step), .rd_ctrl(rd_ctrl), .rd_addr(rd_addr), .rd_ext(rd_ext));

   xrb_addr_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(mgmt_wdata),
      .step(step), .addr(ext_addr));

   generate
      if (ADDR_W == DATA_W) begin : g_rb_full
         assign addr_rb = ext_addr;
      end else begin : g_rb_ext
         assign addr_rb = {{(DATA_W-ADDR_W){1'b0}}, ext_addr};
      end
   endgenerate

   assign ext_wdata = mgmt_wdata;

   always_comb begin
      mgmt_rdata = '0;
      if (rd_ctrl)      mgmt_rdata = ctrl_rb;
      else if (rd_addr) mgmt_rdata = addr_rb;
      else if (rd_ext)  mgmt_rdata = ext_rdata;
   end

   a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr && ext_rd));
   a_r3_no_strobe_addr_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == xrb_pkg::FN_ADDR) |-> !(ext_wr || ext_rd));
   a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_wr || ext_rd) && fn == xrb_pkg::FN_DATA) |=> $stable(ext_addr));
   a_r8_read_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd && fn == xrb_pkg::FN_INC_W) |=> $stable(ext_addr));
   a_r4_read_source: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |-> (mgmt_rd && mgmt_rdata == ext_rdata));
endmodule

// File: tb/xreg_window_bridge_test.sv
`timescale 1ns/1ps
module xreg_window_bridge_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic mgmt_wr = 0, mgmt_rd = 0;
   logic [4:0] mgmt_reg = 0;
   logic [15:0] mgmt_wdata = 0, mgmt_rdata, ext_addr, ext_wdata, ext_rdata;
   logic [4:0] ext_dev;
   logic ext_wr, ext_rd;

   always #2.5 clk = ~clk;

   xreg_window_bridge uut (.*);

   function automatic logic [15:0] backend(input logic [4:0] d, input logic [15:0] a);
      return a ^ {d, 11'h2C5};
   endfunction
   assign ext_rdata = backend(ext_dev, ext_addr);

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [4:0] m_dev = 0;
   logic [1:0] m_fn = 0;
   logic [15:0] m_addr = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic acc(input bit w, input bit r, input logic [4:0] rg, input logic [15:0] d, input string req);
      bit xw, xr;
      logic [15:0] er;
      bit ro = r && !w;
      xw = w && rg == 5'd14 && m_fn != 2'b00;
      xr = ro && rg == 5'd14 && m_fn != 2'b00;
      er = 16'h0;
      if (ro && rg == 5'd13) er = {m_fn, 9'h0, m_dev};
      else if (ro && rg == 5'd14) er = (m_fn == 2'b00) ? m_addr : backend(m_dev, m_addr);
      @(negedge clk);
      mgmt_wr = w; mgmt_rd = r; mgmt_reg = rg; mgmt_wdata = d;
      #1;
      chk(ext_wr == xw, {req, " ext_wr"}, 32'(ext_wr), 32'(xw));
      chk(ext_rd == xr, {req, " ext_rd"}, 32'(ext_rd), 32'(xr));
      chk(mgmt_rdata == er, {req, " mgmt_rdata"}, 32'(mgmt_rdata), 32'(er));
      if (xw || xr) begin
         chk(ext_addr == m_addr, {req, " ext_addr"}, 32'(ext_addr), 32'(m_addr));
         chk(ext_dev == m_dev, {req, " ext_dev"}, 32'(ext_dev), 32'(m_dev));
      end
      if (xw) chk(ext_wdata == d, {req, " ext_wdata"}, 32'(ext_wdata), 32'(d));
      if (w && rg == 5'd13) begin m_dev = d[4:0]; m_fn = d[15:14]; end
      else if (w && rg == 5'd14) begin
         if (m_fn == 2'b00) m_addr = d;
         else if (m_fn[1]) m_addr = m_addr + 16'd1;
      end else if (ro && rg == 5'd14 && m_fn == 2'b10) m_addr = m_addr + 16'd1;
      @(posedge clk); #1;
      mgmt_wr = 0; mgmt_rd = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      acc(0, 1, 5'd13, 0, "R1 ctrl");
      acc(0, 1, 5'd14, 0, "R1 addr");
      // R2 R3 R11 R4: full read sequence
      acc(1, 0, 5'd13, 16'hFFE7, "R2 ctrl write");
      acc(0, 1, 5'd13, 0, "R2 readback");
      acc(1, 0, 5'd13, 16'h0007, "R2 addr mode");
      acc(1, 0, 5'd14, 16'h0032, "R3 load");
      acc(0, 1, 5'd14, 0, "R11 addr read");
      acc(1, 0, 5'd13, 16'h4007, "R2 data fn");
      acc(0, 1, 5'd14, 0, "R4 read");
      acc(0, 1, 5'd14, 0, "R6 read again");
      // R5 R6 write no increment
      acc(1, 0, 5'd14, 16'hA5A5, "R5 write");
      acc(1, 0, 5'd14, 16'h5A5A, "R6 write again");
      // R7 / R9 wrap
      acc(1, 0, 5'd13, 16'h0011, "R9 setup");
      acc(1, 0, 5'd14, 16'hFFFE, "R9 load");
      acc(1, 0, 5'd13, 16'hC011, "R8 fn");
      acc(0, 1, 5'd14, 0, "R8 read hold");
      acc(1, 0, 5'd14, 16'h1111, "R8 write step");
      acc(1, 0, 5'd14, 16'h2222, "R9 wrap write");
      acc(1, 0, 5'd13, 16'h8011, "R7 fn");
      acc(0, 1, 5'd14, 0, "R7 read step");
      acc(1, 0, 5'd14, 16'h3333, "R7 write step");
      acc(0, 1, 5'd14, 0, "R7 read after");
      // R10 foreign registers
      acc(1, 0, 5'd5, 16'hFFFF, "R10 write");
      acc(0, 1, 5'd12, 0, "R10 read");
      acc(0, 1, 5'd14, 0, "R10 state kept");
      // R12 simultaneous
      acc(1, 1, 5'd14, 16'h7777, "R12 both");
      acc(1, 1, 5'd13, 16'h0003, "R12 ctrl both");
      acc(0, 1, 5'd14, 0, "R12 after");
      // random mix
      for (int i = 0; i < 600; i++) begin
         int k = $urandom_range(0, 9);
         logic [4:0] rg = (k < 3) ? 5'd13 : (k < 8) ? 5'd14 : 5'($urandom_range(0, 31));
         logic [15:0] d = 16'($urandom);
         if ($urandom_range(0, 15) == 0) d = 16'hFFFF;
         acc($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, rg, d, "R7 R8 random");
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule